// File: doc/BRIEF.md
# Function Block Input/Output Router

This block is the routing front end of one programmable digital function block. It picks the function's clock and its data from two banks of sixteen candidate signals each. It can pass the chosen clock straight through, or resample it through a two-stage sampler onto the system clock. It then places the function's primary and auxiliary results onto a four-line shared row bus. Each row line is driven as a data bit together with an output enable.

The design runs on one fast clock, which is the double-rate system clock. A base-rate enable input is high on every second cycle. Resampling can run on every fast cycle or only on the cycles where the base-rate enable is high. While resampling is on, the block also gives the function a one-cycle strobe on each synchronized rising edge. Two configuration words and a function-mode input are captured on each clock edge and reset to zero.

The auxiliary input that the block hands to the function depends on the mode. In dead-band mode it is the previous block's primary output, taken without any selection. In SPI-slave mode the auxiliary output fields are given a new meaning. They then choose and force an active-low slave-select, and the auxiliary row drivers are switched off.

Top module: `blk_io_router`

## Requirements
- R1: After reset, every captured configuration field is zero. No row line is enabled, the rise strobe is low, fnClk follows clkSrc[0], fnData follows dataSrc[0] and fnAuxIn is 1.
- R2: inCfg[3:0] picks which clkSrc bit becomes the selected clock. With resampling off, fnClk equals that bit in the same cycle.
- R3: inCfg[7:4] picks which dataSrc bit appears on fnData.
- R4: When outCfg[2] is 1, row line number outCfg[1:0] has rowOe high and rowData equal to funcPrimary. A line that nothing enables has rowOe low and rowData low.
- R5: Outside SPI-slave mode, when outCfg[5] is 1, row line number outCfg[4:3] has rowOe high and carries funcAux.
- R6: When the primary and auxiliary outputs are both enabled onto the same line, that line carries funcPrimary.
- R7: In SPI-slave mode (funcMode = 2), the auxiliary output never drives the row bus. In this mode fnAuxIn is the active-low slave-select, taken from auxSrc[outCfg[4:3]].
- R8: In SPI-slave mode, outCfg[5] = 1 forces fnAuxIn to 0 whatever the value of auxSrc.
- R9: In dead-band mode (funcMode = 1), fnAuxIn equals prevPrimary. In general mode (funcMode = 0 or 3), fnAuxIn is 1.
- R10: With outCfg[6] = 1, the selected clock is sampled through two stages and fnClk is the second stage. Sampling happens on every cycle when outCfg[7] = 0, and only on cycles with baseEn high when outCfg[7] = 1. Between samples the stages hold.
- R11: fnClkRise is high for exactly one cycle each time the synchronized clock goes from 0 to 1, in the cycle where fnClk first shows the 1. It is low whenever resampling is off.
- R12: Configuration and mode inputs take effect at the clock edge that captures them, and not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock (double-rate system clock) |
| rst_n | input | 1 | Asynchronous active-low reset |
| baseEn | input | 1 | High on cycles of the base-rate system clock |
| inCfg | input | 8 | Source selects: [3:0] clock, [7:4] data |
| outCfg | input | 8 | [1:0] primary line, [2] primary enable, [4:3] aux line / slave-select source, [5] aux enable / slave-select force, [6] resample on, [7] resample at base rate |
| funcMode | input | 2 | 0 general, 1 dead-band, 2 SPI slave, 3 treated as general |
| clkSrc | input | 16 | Candidate clock sources |
| dataSrc | input | 16 | Candidate data sources |
| auxSrc | input | 4 | Auxiliary inputs used for slave-select |
| prevPrimary | input | 1 | Primary output of the previous block |
| funcPrimary | input | 1 | Function's primary output |
| funcAux | input | 1 | Function's auxiliary output |
| fnClk | output | 1 | Clock handed to the function |
| fnClkRise | output | 1 | One-cycle strobe on a synchronized rise |
| fnData | output | 1 | Data handed to the function |
| fnAuxIn | output | 1 | Auxiliary input to the function (reference or slave-select) |
| rowData | output | 4 | Row bus data |
| rowOe | output | 4 | Row bus output enables |

## Verification
The bench builds the block with its defaults: sixteen sources per bank, four row lines and a two-stage sampler. With these values every select code and every row line can be reached. Random configurations that change every few cycles produce both primary and auxiliary collisions on the same line, and both sampling rates against the alternating base-rate enable. Slow square-wave clock phases give clean synchronized rises, so the strobe timing can be compared cycle by cycle with the reference model.

// File: rtl/blk_io_pkg.sv
package blk_io_pkg;
  localparam int SRC_N  = 16;
  localparam int LINE_N = 4;
  localparam int SEL_W  = $clog2(SRC_N);
  localparam int LINE_W = $clog2(LINE_N);
  localparam int IN_W   = 2 * SEL_W;
  localparam int OUT_W  = 2 * (LINE_W + 1) + 2;

  typedef enum logic [1:0] {
    MODE_GEN   = 2'd0,
    MODE_DBAND = 2'd1,
    MODE_SPIS  = 2'd2,
    MODE_RSVD  = 2'd3
  } func_mode_e;

  typedef struct packed {
    logic [SEL_W-1:0]  clkSel;
    logic [SEL_W-1:0]  dataSel;
    logic [LINE_N-1:0] priMask;
    logic [LINE_N-1:0] auxMask;
    logic [LINE_W-1:0] ssSel;
    logic              ssForce;
    logic              ssMode;
    logic              refBypass;
    logic              syncEn;
    logic              syncTick;
  } route_strb_t;
endpackage

// File: rtl/blk_io_route_ctrl.sv
module blk_io_route_ctrl
  import blk_io_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             baseEn,
  input  logic [IN_W-1:0]  inCfg,
  input  logic [OUT_W-1:0] outCfg,
  input  logic [1:0]       funcMode,
  output route_strb_t      strb
);
  localparam int PRI_SEL_LO  = 0;
  localparam int PRI_EN_BIT  = LINE_W;
  localparam int AUX_SEL_LO  = LINE_W + 1;
  localparam int AUX_EN_BIT  = 2 * LINE_W + 1;
  localparam int SYNC_EN_BIT = 2 * LINE_W + 2;
  localparam int SYNC_BASE   = 2 * LINE_W + 3;

  logic [IN_W-1:0]  inQ;
  logic [OUT_W-1:0] outQ;
  func_mode_e       modeQ;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      inQ   <= '0;
      outQ  <= '0;
      modeQ <= MODE_GEN;
    end else begin
      inQ   <= inCfg;
      outQ  <= outCfg;
      modeQ <= func_mode_e'(funcMode);
    end
  end

  logic [LINE_W-1:0] priSel, auxSel;
  logic priEn, auxEn, syncOn, syncSlow, isSpis;

  always_comb begin
    priSel   = outQ[PRI_SEL_LO +: LINE_W];
    auxSel   = outQ[AUX_SEL_LO +: LINE_W];
    priEn    = outQ[PRI_EN_BIT];
    auxEn    = outQ[AUX_EN_BIT];
    syncOn   = outQ[SYNC_EN_BIT];
    syncSlow = outQ[SYNC_BASE];
    isSpis   = (modeQ == MODE_SPIS);
  end

  logic [LINE_N-1:0] priMaskW, auxMaskW;
  for (genvar g = 0; g < LINE_N; g++) begin : g_mask
    assign priMaskW[g] = priEn && (priSel == LINE_W'(g));
    assign auxMaskW[g] = auxEn && !isSpis && (auxSel == LINE_W'(g));
  end

  always_comb begin
    strb.clkSel    = inQ[SEL_W-1:0];
    strb.dataSel   = inQ[IN_W-1:SEL_W];
    strb.priMask   = priMaskW;
    strb.auxMask   = auxMaskW;
    strb.ssSel     = auxSel;
    strb.ssForce   = auxEn;
    strb.ssMode    = isSpis;
    strb.refBypass = (modeQ == MODE_DBAND);
    strb.syncEn    = syncOn;
    strb.syncTick  = syncOn && (syncSlow ? baseEn : 1'b1);
  end

  // R10
  slow_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (strb.syncTick && outQ[SYNC_BASE]) |-> baseEn);
endmodule

// File: rtl/blk_io_route_dp.sv
module blk_io_route_dp
  import blk_io_pkg::*;
#(
  parameter int SYNC_STAGES = 2
)(
  input  logic              clk,
  input  logic              rst_n,
  input  route_strb_t       strb,
  input  logic [SRC_N-1:0]  clkSrc,
  input  logic [SRC_N-1:0]  dataSrc,
  input  logic [LINE_N-1:0] auxSrc,
  input  logic              prevPrimary,
  input  logic              funcPrimary,
  input  logic              funcAux,
  output logic              fnClk,
  output logic              fnClkRise,
  output logic              fnData,
  output logic              fnAuxIn,
  output logic [LINE_N-1:0] rowData,
  output logic [LINE_N-1:0] rowOe
);
  localparam int LAST = SYNC_STAGES - 1;

  logic selClk;
  logic [SYNC_STAGES-1:0] stg;
  logic riseQ;

  assign selClk = clkSrc[strb.clkSel];
  assign fnData = dataSrc[strb.dataSel];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg   <= '0;
      riseQ <= 1'b0;
    end else if (strb.syncTick) begin
      stg   <= {stg[LAST-1:0], selClk};
      riseQ <= stg[LAST-1] & ~stg[LAST];
    end else begin
      riseQ <= 1'b0;
    end
  end

  assign fnClk     = strb.syncEn ? stg[LAST] : selClk;
  assign fnClkRise = riseQ & strb.syncEn;

  always_comb begin
    if (strb.refBypass)   fnAuxIn = prevPrimary;
    else if (strb.ssMode) fnAuxIn = strb.ssForce ? 1'b0 : auxSrc[strb.ssSel];
    else                  fnAuxIn = 1'b1;
  end

  for (genvar g = 0; g < LINE_N; g++) begin : g_row
    assign rowOe[g]   = strb.priMask[g] | strb.auxMask[g];
    assign rowData[g] = strb.priMask[g] ? funcPrimary
                      : (strb.auxMask[g] ? funcAux : 1'b0);
    // R4
    quiet_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !rowOe[g] |-> !rowData[g]);
  end

  // R11
  rise_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fnClkRise |=> !fnClkRise);
  // R11
  rise_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fnClkRise |-> fnClk);
  // R10
  sync_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !strb.syncTick |=> $stable(stg));
  // R7
  spis_drv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    strb.ssMode |-> ($countones(rowOe) <= 1));
endmodule

// File: rtl/blk_io_router.sv
module blk_io_router
  import blk_io_pkg::*;
#(
  parameter int SYNC_STAGES = 2
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              baseEn,
  input  logic [IN_W-1:0]   inCfg,
  input  logic [OUT_W-1:0]  outCfg,
  input  logic [1:0]        funcMode,
  input  logic [SRC_N-1:0]  clkSrc,
  input  logic [SRC_N-1:0]  dataSrc,
  input  logic [LINE_N-1:0] auxSrc,
  input  logic              prevPrimary,
  input  logic              funcPrimary,
  input  logic              funcAux,
  output logic              fnClk,
  output logic              fnClkRise,
  output logic              fnData,
  output logic              fnAuxIn,
  output logic [LINE_N-1:0] rowData,
  output logic [LINE_N-1:0] rowOe
);
  route_strb_t strb;

  blk_io_route_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .baseEn(baseEn),
    .inCfg(inCfg), .outCfg(outCfg), .funcMode(funcMode), .strb(strb)
  );

  blk_io_route_dp #(.SYNC_STAGES(SYNC_STAGES)) u_dp (
    .clk(clk), .rst_n(rst_n), .strb(strb),
    .clkSrc(clkSrc), .dataSrc(dataSrc), .auxSrc(auxSrc),
    .prevPrimary(prevPrimary), .funcPrimary(funcPrimary), .funcAux(funcAux),
    .fnClk(fnClk), .fnClkRise(fnClkRise), .fnData(fnData), .fnAuxIn(fnAuxIn),
    .rowData(rowData), .rowOe(rowOe)
  );
endmodule

// File: tb/tb_blk_io_router.sv
module tb_blk_io_router;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic baseEn = 1'b0;
  logic [7:0] inCfg = '0, outCfg = '0;
  logic [1:0] funcMode = '0;
  logic [15:0] clkSrc = '0, dataSrc = '0;
  logic [3:0] auxSrc = '0;
  logic prevPrimary = 1'b0, funcPrimary = 1'b0, funcAux = 1'b0;
  logic fnClk, fnClkRise, fnData, fnAuxIn;
  logic [3:0] rowData, rowOe;

  int errors = 0;
  int checks = 0;
  bit done = 0;
  bit slowClk = 0;
  int slowCnt = 0;

  always #2 clk = ~clk;

  blk_io_router dut (
    .clk(clk), .rst_n(rst_n), .baseEn(baseEn), .inCfg(inCfg), .outCfg(outCfg),
    .funcMode(funcMode), .clkSrc(clkSrc), .dataSrc(dataSrc), .auxSrc(auxSrc),
    .prevPrimary(prevPrimary), .funcPrimary(funcPrimary), .funcAux(funcAux),
    .fnClk(fnClk), .fnClkRise(fnClkRise), .fnData(fnData), .fnAuxIn(fnAuxIn),
    .rowData(rowData), .rowOe(rowOe)
  );

  // reference model state (R12: captured at the edge)
  bit [7:0] mIn = 0, mOut = 0;
  bit [1:0] mMode = 0;
  bit ms1 = 0, ms2 = 0, mRise = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      mIn = 0; mOut = 0; mMode = 0; ms1 = 0; ms2 = 0; mRise = 0;
    end else begin
      bit tick;
      tick = mOut[6] && (mOut[7] ? baseEn : 1'b1);
      if (tick) begin
        mRise = ms1 && !ms2;
        ms2 = ms1;
        ms1 = clkSrc[mIn[3:0]];
      end else begin
        mRise = 0;
      end
      mIn = inCfg; mOut = outCfg; mMode = funcMode;
    end
  end

  task automatic chk(input string req, input logic [3:0] act, input logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s at %0t: actual=%h expected=%h", req, $time, act, exp);
    end
  endtask

  always @(negedge clk) begin
    #1;
    if (rst_n && !done) begin
      logic [3:0] eOe, eData;
      logic eClk, eAux;
      eOe = 0; eData = 0;
      for (int i = 0; i < 4; i++) begin
        bit p, a;
        p = mOut[2] && (mOut[1:0] == i);
        a = (mMode != 2) && mOut[5] && (mOut[4:3] == i);
        eOe[i] = p | a;
        eData[i] = p ? funcPrimary : (a ? funcAux : 1'b0);
      end
      eClk = mOut[6] ? ms2 : clkSrc[mIn[3:0]];
      case (mMode)
        2'd1: eAux = prevPrimary;
        2'd2: eAux = mOut[5] ? 1'b0 : auxSrc[mOut[4:3]];
        default: eAux = 1'b1;
      endcase
      chk(mOut[6] ? "R10 fnClk" : "R2 fnClk", {3'b0, fnClk}, {3'b0, eClk});
      chk("R11 fnClkRise", {3'b0, fnClkRise}, {3'b0, mRise & mOut[6]});
      chk("R3 fnData", {3'b0, fnData}, {3'b0, dataSrc[mIn[7:4]]});
      chk("R4 R5 R6 R7 rowOe", rowOe, eOe);
      chk("R4 R5 R6 rowData", rowData, eData);
      chk("R7 R8 R9 fnAuxIn", {3'b0, fnAuxIn}, {3'b0, eAux});
    end
  end

  task automatic drive(input int n, input bit slow);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      baseEn = ~baseEn;
      slowCnt++;
      if (slowCnt % 5 == 0) slowClk = ~slowClk;
      clkSrc = slow ? {16{slowClk}} : 16'($urandom);
      dataSrc = 16'($urandom);
      auxSrc = 4'($urandom);
      prevPrimary = 1'($urandom);
      funcPrimary = 1'($urandom);
      funcAux = 1'($urandom);
    end
  endtask

  task automatic setCfg(input logic [7:0] i, input logic [7:0] o, input logic [1:0] m);
    @(negedge clk);
    inCfg = i; outCfg = o; funcMode = m;
  endtask

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    clkSrc = 16'h0001; dataSrc = 16'h0001;
    #1;
    // R1: reset state
    chk("R1 rowOe", rowOe, 4'h0);
    chk("R1 fnClkRise", {3'b0, fnClkRise}, 4'h0);
    chk("R1 fnClk", {3'b0, fnClk}, 4'h1);
    chk("R1 fnData", {3'b0, fnData}, 4'h1);
    chk("R1 fnAuxIn", {3'b0, fnAuxIn}, 4'h1);
    // R6: same-line collision, primary wins
    setCfg(8'h00, 8'h36, 2'd0); drive(20, 0);
    // R8: SPI-slave forced select
    setCfg(8'h21, 8'h3C, 2'd2); drive(20, 0);
    // R7: SPI-slave selected input
    setCfg(8'h21, 8'h1C, 2'd2); drive(20, 0);
    // R9: dead-band reference
    setCfg(8'h5A, 8'h05, 2'd1); drive(20, 0);
    // R10 R11: both resampling rates on a slow clock
    setCfg(8'h07, 8'h40, 2'd0); drive(60, 1);
    setCfg(8'h07, 8'hC0, 2'd0); drive(60, 1);
    // random sweep
    for (int r = 0; r < 300; r++) begin
      setCfg(8'($urandom), 8'($urandom), 2'($urandom));
      drive(12, r[0]);
    end
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      errors++; checks++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule